// File: doc/BRIEF.md
# Erased-Chunk Parity Filter and Detector

This block deals with the erased-page case around a Reed-Solomon protected flash chunk, made of data bytes and a small parity field. An erased flash page reads back as all ones. The parity that the encoder computes for an all-ones chunk is not all ones. Without this block, erased pages and pages filled by partial (subpage) programming would disagree with their parity fields.

On the write side the block takes the parity word from the encoder. If the word equals the fixed erased-chunk signature, the block puts out all-ones. Any other word passes through unchanged. On the read side the block receives the stored parity bytes and then the data bytes as a byte stream, with a valid strobe and a last marker. It issues one verdict pulse per chunk. The verdict either marks the chunk as erased, so decoding is skipped and zero corrections are reported, or it requests a decode. A few probe positions let a non-blank chunk be rejected before the whole stream has been seen.

Top module: `erased_chunk_filter`

## Requirements
- R1: The read stream carries PAR_BYTES parity bytes (parity byte 0 first) followed by DATA_BYTES data bytes, one byte per cycle while `rd_valid` is high, with `rd_last` on the final byte. Cycles with `rd_valid` low do not advance the position and never produce a verdict in the following cycle.
- R2: When `wr_in_valid` is high and `wr_par_in` equals the signature, `wr_out_valid` is high one cycle later and `wr_par_out` is all 0xFF. The signature is the byte sequence CD 9D 90 58 F4 8B FF B7 6F, with parity byte k held in bits [8k+7:8k], so byte 0 (0xCD) is in bits [7:0].
- R3: Any other `wr_par_in` value, including all 0xFF and words that differ from the signature in a single bit, appears unchanged on `wr_par_out` one cycle later, with `wr_out_valid` high.
- R4: A chunk is reported erased (`vd_erased` high with `vd_valid`) only when it has exactly PAR_BYTES+DATA_BYTES bytes and every byte is 0xFF.
- R5: A byte other than 0xFF at stream position 0 (parity byte 0), at data byte 0, at data byte DATA_BYTES/2 or at data byte DATA_BYTES-1 causes a decode-required verdict in the cycle right after that byte.
- R6: A byte other than 0xFF at any other position causes a decode-required verdict in the cycle after the byte carrying `rd_last`. A chunk that is too short or too long is not erased, and its verdict also comes in the cycle after its last byte.
- R7: Each chunk produces exactly one verdict pulse. After an early rejection, the remaining bytes up to and including `rd_last` produce no further pulse.
- R8: `dec_start` pulses together with every decode-required verdict and never with an erased verdict. An erased chunk therefore starts no decode and reports zero corrections.
- R9: Each chunk is judged on its own bytes. The all-ones accumulator and the position restart after every `rd_last`, so a rejected chunk does not affect the chunk that follows it.
- R10: While in reset and right after it, `vd_valid`, `vd_erased`, `dec_start` and `wr_out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_in_valid | input | 1 | Encoder parity word is valid |
| wr_par_in | input | PAR_BYTES*8 | Encoder parity, byte k in bits [8k+7:8k] |
| wr_out_valid | output | 1 | Filtered parity word is valid |
| wr_par_out | output | PAR_BYTES*8 | Parity to store, with the signature replaced by all ones |
| rd_valid | input | 1 | Read stream byte is valid |
| rd_byte | input | 8 | Read stream byte (parity bytes first, then data bytes) |
| rd_last | input | 1 | Final byte of the chunk |
| vd_valid | output | 1 | Verdict pulse |
| vd_erased | output | 1 | With `vd_valid`: the chunk is erased, so skip decoding |
| dec_start | output | 1 | Start the decoder for this chunk |

## Verification
The bench builds the block with DATA_BYTES set to 16 and the standard 9-byte parity field. This makes the stream 25 bytes long, so every position can be spoiled in turn. The four probe positions and the ordinary positions fall close together, and the bench checks the exact verdict cycle for each of them. On the write side it flips every single bit of the signature in turn, and it also replays the sweep with idle gaps in the stream, with short and long chunks, and with a blank chunk sent right after a rejected one.

// File: rtl/erased_chunk_filter.sv
module erased_chunk_filter #(
  parameter int DATA_BYTES = 512,
  parameter int PAR_BYTES  = 9,
  parameter logic [PAR_BYTES*8-1:0] ERASED_SIG = 72'h6F_B7_FF_8B_F4_58_90_9D_CD
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_in_valid,
  input  logic [PAR_BYTES*8-1:0] wr_par_in,
  output logic                   wr_out_valid,
  output logic [PAR_BYTES*8-1:0] wr_par_out,
  input  logic                   rd_valid,
  input  logic [7:0]             rd_byte,
  input  logic                   rd_last,
  output logic                   vd_valid,
  output logic                   vd_erased,
  output logic                   dec_start
);
  localparam int TOTAL = PAR_BYTES + DATA_BYTES;
  localparam int IW    = $clog2(TOTAL + 1);
  localparam logic [IW-1:0] P_PAR0  = '0;
  localparam logic [IW-1:0] P_DAT0  = IW'(PAR_BYTES);
  localparam logic [IW-1:0] P_MID   = IW'(PAR_BYTES + DATA_BYTES / 2);
  localparam logic [IW-1:0] P_END   = IW'(TOTAL - 1);
  localparam logic [IW-1:0] P_SAT   = IW'(TOTAL);

  // write path: signature substitution
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_out_valid <= 1'b0;
      wr_par_out   <= '0;
    end else begin
      wr_out_valid <= wr_in_valid;
      if (wr_in_valid)
        wr_par_out <= (wr_par_in == ERASED_SIG) ? '1 : wr_par_in;
    end
  end

  // read path: blank detection
  logic [IW-1:0] pos;
  logic [7:0]    acc;
  logic          skip;

  wire byte_ff  = (rd_byte == 8'hFF);
  wire is_probe = (pos == P_PAR0) || (pos == P_DAT0) || (pos == P_MID) || (pos == P_END);
  wire all_ff   = ((acc & rd_byte) == 8'hFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= '0;
      acc       <= 8'hFF;
      skip      <= 1'b0;
      vd_valid  <= 1'b0;
      vd_erased <= 1'b0;
    end else begin
      vd_valid <= 1'b0;
      if (rd_valid) begin
        if (rd_last) begin
          pos  <= '0;
          acc  <= 8'hFF;
          skip <= 1'b0;
          if (!skip) begin
            vd_valid  <= 1'b1;
            vd_erased <= all_ff && (pos == P_END);
          end
        end else begin
          if (pos != P_SAT) pos <= pos + 1'b1;
          if (!skip) begin
            if (is_probe && !byte_ff) begin
              vd_valid  <= 1'b1;
              vd_erased <= 1'b0;
              skip      <= 1'b1;
            end else begin
              acc <= acc & rd_byte;
            end
          end
        end
      end
    end
  end

  assign dec_start = vd_valid & ~vd_erased;

  AST_WR_SIG_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_in_valid && (wr_par_in == ERASED_SIG) |=> wr_out_valid && (wr_par_out == '1)); // R2
  AST_WR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_in_valid && (wr_par_in != ERASED_SIG) |=> wr_out_valid && (wr_par_out == $past(wr_par_in))); // R3
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !vd_valid); // R1
  AST_BAD_LAST_NOT_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_last && !byte_ff |=> !vd_erased); // R4
  AST_EARLY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !skip && (pos == P_PAR0) && !byte_ff |=> vd_valid && dec_start); // R5
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && skip |=> !vd_valid); // R7
endmodule

// File: tb/erased_chunk_filter_test.sv
module erased_chunk_filter_test;
  localparam int DB = 16;
  localparam int PB = 9;
  localparam int TOT = DB + PB;

  logic clk = 0, rst_n = 0;
  logic wr_in_valid = 0;
  logic [PB*8-1:0] wr_par_in = '0;
  logic wr_out_valid;
  logic [PB*8-1:0] wr_par_out;
  logic rd_valid = 0, rd_last = 0;
  logic [7:0] rd_byte = 0;
  logic vd_valid, vd_erased, dec_start;

  erased_chunk_filter #(.DATA_BYTES(DB), .PAR_BYTES(PB)) uut (
    .clk(clk), .rst_n(rst_n), .wr_in_valid(wr_in_valid), .wr_par_in(wr_par_in),
    .wr_out_valid(wr_out_valid), .wr_par_out(wr_par_out), .rd_valid(rd_valid),
    .rd_byte(rd_byte), .rd_last(rd_last), .vd_valid(vd_valid), .vd_erased(vd_erased),
    .dec_start(dec_start));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int pulses, p_cyc, p_er, p_dec;
  logic [PB*8-1:0] sig;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (vd_valid) begin
    pulses++; p_cyc = cyc; p_er = vd_erased; p_dec = dec_start;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [PB*8-1:0] v, input string req);
    logic [PB*8-1:0] e;
    e = (v == sig) ? '1 : v;
    @(negedge clk); wr_in_valid = 1; wr_par_in = v;
    @(negedge clk); wr_in_valid = 0;
    chk(req, wr_out_valid, 1);
    chk(req, wr_par_out, e);
  endtask

  // bad < 0: no spoiled byte
  task automatic chunk(input int len, input int bad, input logic [7:0] bv, input bit gap, input string req);
    int rej_pos, t_rej, exp_er;
    bit probe;
    pulses = 0; t_rej = -1;
    probe = (bad == 0) || (bad == PB) || (bad == PB + DB/2) || (bad == TOT - 1);
    rej_pos = (bad >= 0 && bad < len && probe) ? bad : len - 1;
    exp_er = (bad < 0 || bad >= len) && (len == TOT);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rd_valid = 1; rd_byte = (i == bad) ? bv : 8'hFF; rd_last = (i == len - 1);
      if (i == rej_pos) t_rej = cyc;
      if (gap && i != len - 1) begin @(negedge clk); rd_valid = 0; end
    end
    @(negedge clk); rd_valid = 0; rd_last = 0;
    repeat (3) @(negedge clk);
    chk({req, " R7 pulses"}, pulses, 1);
    chk({req, " verdict cycle"}, p_cyc, t_rej + 1);
    chk({req, " R4 erased"}, p_er, exp_er);
    chk({req, " R8 dec_start"}, p_dec, !exp_er);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    sig = 72'h6F_B7_FF_8B_F4_58_90_9D_CD;
    repeat (3) @(negedge clk);
    chk("R10 vd_valid", vd_valid, 0);
    chk("R10 wr_out_valid", wr_out_valid, 0);
    chk("R10 dec_start", dec_start, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 vd_erased", vd_erased, 0);

    wr(sig, "R2 signature");
    wr('1, "R3 all ones");
    wr('0, "R3 zero");
    for (int k = 0; k < PB*8; k++) wr(sig ^ ((PB*8)'(1) << k), "R3 bit flip");
    wr(sig, "R2 signature again");

    chunk(TOT, -1, 8'h00, 0, "R4 blank");
    for (int b = 0; b < TOT; b++) begin
      bit pr;
      pr = (b == 0) || (b == PB) || (b == PB + DB/2) || (b == TOT - 1);
      chunk(TOT, b, 8'hFE, 0, pr ? "R5 probe" : "R6 plain");
      chunk(TOT, -1, 8'h00, 0, "R9 blank after reject");
    end
    for (int b = 0; b < TOT; b += 3) chunk(TOT, b, 8'h7F, 1, "R1 gapped");
    chunk(TOT, -1, 8'h00, 1, "R1 gapped blank");
    chunk(TOT - 1, -1, 8'h00, 0, "R6 short");
    chunk(TOT + 1, -1, 8'h00, 0, "R6 long");
    chunk(1, -1, 8'h00, 0, "R6 single");
    chunk(TOT, -1, 8'h00, 0, "R9 blank after odd lengths");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule